// File: doc/BRIEF.md
# Regulator start-up and fault sequencer

This block is the digital sequencer of a multiphase buck regulator controller. It runs on the system clock and counts switching cycles, one cycle per pulse on its tick input. It decides, for every power channel, whether the channel output is released (three-state), held low so that the lower switches conduct, or allowed to switch under PWM control. It also gates the reference ramp that drives the error amplifier and produces the power-good indication. The comparators for over-voltage, under-voltage and over-current sit outside the block and reach it as single-bit flags.

A normal start has three timed phases after power-on reset and enable are both satisfied. First the channels stay three-stated while the reference stays at zero. Then the channels are held low for a settling interval. Then PWM is released while a reference code climbs from zero to full scale in equal steps. Power-good follows only when the full soft-start count has elapsed and the output is not under-voltage. An over-voltage sets a latch that only a new power-on reset clears; while it is set, the channels act as a hysteretic crowbar. An over-current forces a hiccup: the channels are released, a long wait is counted, and the soft-start is run again.

Top module: `ssq_top`

## Requirements
- R1: While `por_i` is high or `en_i` is low, every channel reports three-state (code 00) from the next clock on, `pg_o` and `ramp_en_o` are low and `ramp_code_o` is 0.
- R2: A start begins at the first clock edge where `por_i` is low and `en_i` is high; the channels stay three-state for the next 32 ticks and change to forced low (code 01) on the clock of the 32nd tick.
- R3: Forced low lasts 150 further ticks (parameter `SETTLE_CYC`); on the clock of the last of them every channel changes to PWM (code 10) and `ramp_en_o` rises.
- R4: `pg_o` stays low until the 2048th tick counted from the start of R2 and rises on the clock of that tick when `uv_i` is low.
- R5: `ov_i` high sets a latch that holds `pg_o` low; while latched, the channels are forced low one clock after `ov_i` is high and three-state one clock after it is low, and no start is attempted; toggling `en_i` does not clear the latch, only `por_i` high does.
- R6: `uv_i` high pulls `pg_o` low one clock later and has no effect on channel mode or the ramp; `pg_o` returns once `uv_i` is low again.
- R7: `oc_i` high during settling, ramp or regulation three-states every channel on the next clock; after 2048 further ticks the channels go low and the sequence of R3 and R4 repeats, with `pg_o` rising 2048 + 2016 ticks after the fault.
- R8: The hiccup repeats for every later over-current event; `oc_i` while the channels are in a three-state wait is ignored and does not lengthen that wait.
- R9: `ramp_code_o` is 0 when the ramp starts, rises by one every 7 ticks (computed from the 1866 ticks between ramp start and power-good and the 8-bit code width), saturates at 255 and holds there while `ramp_en_o` is high.
- R10: All channels always carry the same mode; channel i occupies bits [2i+1:2i] of `mode_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_i | input | 1 | Power-on reset flag from the supply monitor |
| en_i | input | 1 | Converter enable |
| tick_i | input | 1 | One-clock pulse per switching cycle |
| ov_i | input | 1 | Over-voltage comparator flag, hysteresis applied outside |
| uv_i | input | 1 | Under-voltage comparator flag |
| oc_i | input | 1 | Over-current comparator flag |
| mode_o | output | 2*NUM_CH | Per-channel mode: 00 three-state, 01 forced low, 10 PWM |
| ramp_en_o | output | 1 | Reference ramp enable |
| ramp_code_o | output | CODE_W | Current reference ramp code |
| pg_o | output | 1 | Power-good |

## Verification
The hardest situation to reach is a second over-current hiccup that itself contains an ignored over-current pulse, because it needs a full soft-start, a fault in the ramp, a pulse placed inside the 2048-tick wait and a further fault in the settle interval of the rerun. The stimulus walks there in one continuous run, measuring each landmark in ticks from the fault edge. The latched over-voltage is reached only after a completed start and is then probed with enable toggles and a long idle stretch to show that no start is attempted until a power-on reset.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

    typedef enum logic [1:0] {
        CH_TRI = 2'b00,
        CH_LOW = 2'b01,
        CH_PWM = 2'b10
    } ch_mode_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_SETTLE,
        ST_RAMP,
        ST_RUN,
        ST_CLAMP
    } seq_state_e;

    function automatic ch_mode_e mode_for(seq_state_e s, logic ov_now);
        case (s)
            ST_SETTLE:      return CH_LOW;
            ST_RAMP,
            ST_RUN:         return CH_PWM;
            ST_CLAMP:       return ov_now ? CH_LOW : CH_TRI;
            default:        return CH_TRI;
        endcase
    endfunction

    function automatic logic is_live(seq_state_e s);
        return (s == ST_SETTLE) || (s == ST_RAMP) || (s == ST_RUN);
    endfunction

    function automatic logic ramp_owned(seq_state_e s);
        return (s == ST_RAMP) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/ssq_cnt.sv
module ssq_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/ssq_ramp.sv
module ssq_ramp #(
    parameter int CODE_W = 8,
    parameter int STEP   = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    output logic [CODE_W-1:0] code_o
);
    localparam int SW = (STEP > 1) ? $clog2(STEP) : 1;
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP - 1);

    logic [SW-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            step_q <= '0;
            code_o <= '0;
        end else if (adv) begin
            if (step_q == STEP_LAST) begin
                step_q <= '0;
                if (!(&code_o)) begin
                    code_o <= code_o + 1'b1;
                end
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssq_ovl.sv
module ssq_ovl (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic ov,
    output logic latched_o
);
    always_ff @(posedge clk) begin
        if (rst || por) begin
            latched_o <= 1'b0;
        end else if (ov) begin
            latched_o <= 1'b1;
        end
    end
endmodule

// File: rtl/ssq_top.sv
module ssq_top #(
    parameter int NUM_CH      = 4,
    parameter int INIT_WAIT   = 32,
    parameter int HICCUP_WAIT = 2048,
    parameter int SETTLE_CYC  = 150,
    parameter int PG_CYC      = 2048,
    parameter int CODE_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  por_i,
    input  logic                  en_i,
    input  logic                  tick_i,
    input  logic                  ov_i,
    input  logic                  uv_i,
    input  logic                  oc_i,
    output logic [2*NUM_CH-1:0]   mode_o,
    output logic                  ramp_en_o,
    output logic [CODE_W-1:0]     ramp_code_o,
    output logic                  pg_o
);
    import ssq_pkg::*;

    localparam int RAMP_LEN  = PG_CYC - INIT_WAIT - SETTLE_CYC;
    localparam int RAMP_STEP = ((RAMP_LEN >> CODE_W) < 1) ? 1 : (RAMP_LEN >> CODE_W);
    localparam int SEQ_LEN   = PG_CYC - INIT_WAIT;
    localparam int MAX_SPAN  = (HICCUP_WAIT > PG_CYC) ? HICCUP_WAIT : PG_CYC;
    localparam int CNT_W     = $clog2(MAX_SPAN) + 1;

    localparam logic [CNT_W-1:0] INIT_LAST   = CNT_W'(INIT_WAIT - 1);
    localparam logic [CNT_W-1:0] HICCUP_LAST = CNT_W'(HICCUP_WAIT - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] SEQ_LAST    = CNT_W'(SEQ_LEN - 1);

    seq_state_e        state_q, state_d;
    logic              hic_q, hic_d;
    logic              ovl_q, ovl_d;
    ch_mode_e          mode_q;
    logic              pg_q;
    logic [CNT_W-1:0]  phase_cnt, seq_cnt;
    logic              phase_clr, phase_inc, seq_clr, seq_inc;
    logic              ramp_clr, ramp_adv;
    logic [CNT_W-1:0]  wait_last;

    assign wait_last = hic_q ? HICCUP_LAST : INIT_LAST;
    assign ovl_d     = !por_i && (ovl_q || ov_i);

    always_comb begin
        state_d = state_q;
        hic_d   = hic_q;
        if (por_i || !en_i) begin
            state_d = ST_OFF;
            hic_d   = 1'b0;
        end else if (ovl_d) begin
            state_d = ST_CLAMP;
        end else if (oc_i && is_live(state_q)) begin
            state_d = ST_WAIT;
            hic_d   = 1'b1;
        end else begin
            case (state_q)
                ST_OFF: begin
                    state_d = ST_WAIT;
                    hic_d   = 1'b0;
                end
                ST_WAIT: begin
                    if (tick_i && (phase_cnt == wait_last)) begin
                        state_d = ST_SETTLE;
                        hic_d   = 1'b0;
                    end
                end
                ST_SETTLE: begin
                    if (tick_i && (phase_cnt == SETTLE_LAST)) begin
                        state_d = ST_RAMP;
                    end
                end
                ST_RAMP: begin
                    if (tick_i && (seq_cnt == SEQ_LAST)) begin
                        state_d = ST_RUN;
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase_clr = (state_d != state_q) || (state_d == ST_OFF);
    assign phase_inc = tick_i && ((state_q == ST_WAIT) || (state_q == ST_SETTLE));
    assign seq_clr   = !is_live(state_d);
    assign seq_inc   = tick_i && ((state_q == ST_SETTLE) || (state_q == ST_RAMP));
    assign ramp_clr  = !ramp_owned(state_d);
    assign ramp_adv  = tick_i && (state_q == ST_RAMP);

    ssq_cnt #(.W(CNT_W)) u_phase_cnt (
        .clk (clk),
        .rst (rst),
        .clr (phase_clr),
        .inc (phase_inc),
        .q   (phase_cnt)
    );

    ssq_cnt #(.W(CNT_W)) u_seq_cnt (
        .clk (clk),
        .rst (rst),
        .clr (seq_clr),
        .inc (seq_inc),
        .q   (seq_cnt)
    );

    ssq_ramp #(.CODE_W(CODE_W), .STEP(RAMP_STEP)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .clr    (ramp_clr),
        .adv    (ramp_adv),
        .code_o (ramp_code_o)
    );

    ssq_ovl u_ovl (
        .clk       (clk),
        .rst       (rst),
        .por       (por_i),
        .ov        (ov_i),
        .latched_o (ovl_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            hic_q   <= 1'b0;
            mode_q  <= CH_TRI;
            pg_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            hic_q   <= hic_d;
            mode_q  <= mode_for(state_d, ov_i);
            pg_q    <= (state_d == ST_RUN) && !uv_i;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            assign mode_o[2*g +: 2] = mode_q;
        end
    endgenerate

    assign ramp_en_o = ramp_owned(state_q);
    assign pg_o      = pg_q;

endmodule

// File: rtl/ssq_chk.sv
module ssq_chk #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                por_i,
    input logic                en_i,
    input logic                ov_i,
    input logic                uv_i,
    input logic                oc_i,
    input logic [2*NUM_CH-1:0] mode_o,
    input logic                ramp_en_o,
    input logic [CODE_W-1:0]   ramp_code_o,
    input logic                pg_o,
    input logic                ovl
);
    localparam logic [2*NUM_CH-1:0] ALL_LOW = {NUM_CH{2'b01}};
    localparam logic [2*NUM_CH-1:0] ALL_PWM = {NUM_CH{2'b10}};

    p_off_tri_r1: assert property (@(posedge clk) disable iff (rst)
        (por_i || !en_i) |=> (mode_o == '0 && !pg_o && !ramp_en_o));

    p_ov_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        (ov_i && !por_i && en_i) |=> (mode_o == ALL_LOW && !pg_o));

    p_latched_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (ovl && !ov_i && !por_i) |=> (mode_o != ALL_PWM && !pg_o));

    p_uv_drop_r6: assert property (@(posedge clk) disable iff (rst)
        uv_i |=> !pg_o);

    p_oc_release_r7: assert property (@(posedge clk) disable iff (rst)
        (oc_i && !ov_i && !ovl && en_i && !por_i && mode_o != '0) |=> (mode_o == '0));

    p_ramp_step_r9: assert property (@(posedge clk) disable iff (rst)
        (ramp_code_o != $past(ramp_code_o)) |->
        (ramp_code_o == $past(ramp_code_o) + 1'b1 || ramp_code_o == '0));

    p_pg_full_r4: assert property (@(posedge clk) disable iff (rst)
        pg_o |-> (ramp_en_o && (&ramp_code_o) && mode_o == ALL_PWM));

endmodule

bind ssq_top ssq_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .por_i       (por_i),
    .en_i        (en_i),
    .ov_i        (ov_i),
    .uv_i        (uv_i),
    .oc_i        (oc_i),
    .mode_o      (mode_o),
    .ramp_en_o   (ramp_en_o),
    .ramp_code_o (ramp_code_o),
    .pg_o        (pg_o),
    .ovl         (ovl_q)
);

// File: tb/ssq_top_bench.sv
module ssq_top_bench;
    localparam int NCH  = 4;
    localparam int CW   = 8;
    localparam int INIT = 32;
    localparam int HIC  = 2048;
    localparam int SET  = 150;
    localparam int PGC  = 2048;
    localparam int STEP = 7;
    localparam int SEQ  = PGC - INIT;
    localparam int CMAX = 255;

    logic clk = 0, rst = 1, por = 1, en = 0, tick = 0, ov = 0, uv = 0, oc = 0;
    logic [2*NCH-1:0] mode_o;
    logic             ramp_en_o, pg_o;
    logic [CW-1:0]    ramp_code_o;

    ssq_top u_ssq_top (
        .clk(clk), .rst(rst), .por_i(por), .en_i(en), .tick_i(tick),
        .ov_i(ov), .uv_i(uv), .oc_i(oc),
        .mode_o(mode_o), .ramp_en_o(ramp_en_o), .ramp_code_o(ramp_code_o), .pg_o(pg_o)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, tick_seen = 0, tdiv = 0;
    bit tick_run = 0, cmp_on = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (tick_run) begin
            tdiv = (tdiv + 1) % 2;
            tick = (tdiv == 0);
        end else begin
            tick = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (tick) tick_seen++;
    end

    // behavioural reference: 0 off, 1 wait, 2 settle, 3 ramp, 4 run, 5 clamp
    int m_st = 0, m_cnt = 0, m_seq = 0, m_code = 0, m_step = 0, e_mode = 0;
    bit m_hic = 0, m_ovl = 0, e_pg = 0, e_ren = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_seq = 0; m_code = 0; m_step = 0;
            m_hic = 0; m_ovl = 0; e_mode = 0; e_pg = 0; e_ren = 0;
        end else begin
            bit ovn;
            ovn = !por && (m_ovl || ov);
            if (por || !en) begin
                m_st = 0; m_hic = 0; m_cnt = 0; m_seq = 0;
            end else if (ovn) begin
                m_st = 5;
            end else if (oc && m_st >= 2 && m_st <= 4) begin
                m_st = 1; m_hic = 1; m_cnt = 0; m_seq = 0;
            end else begin
                case (m_st)
                    0: begin m_st = 1; m_cnt = 0; end
                    1: if (tick) begin
                        m_cnt++;
                        if (m_cnt == (m_hic ? HIC : INIT)) begin
                            m_st = 2; m_cnt = 0; m_hic = 0;
                        end
                    end
                    2: if (tick) begin
                        m_cnt++; m_seq++;
                        if (m_cnt == SET) begin m_st = 3; m_cnt = 0; end
                    end
                    3: if (tick) begin
                        m_seq++; m_step++;
                        if (m_step == STEP) begin
                            m_step = 0;
                            if (m_code < CMAX) m_code++;
                        end
                        if (m_seq == SEQ) m_st = 4;
                    end
                    default: ;
                endcase
            end
            m_ovl = ovn;
            if (!(m_st == 3 || m_st == 4)) begin m_code = 0; m_step = 0; end
            e_ren  = (m_st == 3 || m_st == 4);
            e_mode = (m_st == 2) ? 1 : (m_st == 3 || m_st == 4) ? 2 : (m_st == 5 && ov) ? 1 : 0;
            e_pg   = (m_st == 4) && !uv;
        end
    end

    function automatic string mode_req(int s);
        case (s)
            0: return "R1 R10";
            1: return "R2 R10";
            2: return "R3 R10";
            5: return "R5 R10";
            default: return "R3 R10";
        endcase
    endfunction

    always @(negedge clk) begin
        if (cmp_on) begin
            logic [2*NCH-1:0] ev;
            ev = {NCH{e_mode[1:0]}};
            chk(mode_o === ev, mode_req(m_st), "mode", int'(mode_o), int'(ev));
            chk(pg_o === e_pg, uv ? "R6" : (m_st == 5 ? "R5" : "R4"), "pg", int'(pg_o), int'(e_pg));
            chk(ramp_en_o === e_ren, "R9", "ramp_en", int'(ramp_en_o), int'(e_ren));
            chk(ramp_code_o === CW'(m_code), "R9", "ramp_code", int'(ramp_code_o), m_code);
        end
    end

    task automatic wait_mode(input logic [1:0] m, input int t0, output int dt);
        while (mode_o[1:0] !== m) @(negedge clk);
        dt = tick_seen - t0;
    endtask

    task automatic wait_pg(input int t0, output int dt);
        while (pg_o !== 1'b1) @(negedge clk);
        dt = tick_seen - t0;
    endtask

    task automatic start_edge(output int t0);
        @(posedge clk);
        @(negedge clk);
        t0 = tick_seen;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0, dt;
        repeat (3) @(negedge clk);
        chk(mode_o === '0 && pg_o === 0 && ramp_en_o === 0, "R1", "reset state", int'(mode_o), 0);
        cmp_on = 1;
        rst = 0; en = 1; tick_run = 1;
        repeat (20) @(negedge clk);
        chk(mode_o === '0, "R1", "por held", int'(mode_o), 0);

        // normal start
        por = 0;
        start_edge(t0);
        wait_mode(2'b01, t0, dt); chk(dt == INIT, "R2", "ticks to forced low", dt, INIT);
        wait_mode(2'b10, t0, dt); chk(dt == INIT + SET, "R3", "ticks to pwm", dt, INIT + SET);
        wait_pg(t0, dt);          chk(dt == PGC, "R4", "ticks to power good", dt, PGC);
        chk(ramp_code_o == CW'(CMAX), "R9", "ramp at full scale", int'(ramp_code_o), CMAX);

        // under-voltage only drops power-good
        uv = 1;
        @(negedge clk); @(negedge clk);
        chk(pg_o === 0, "R6", "pg under uv", int'(pg_o), 0);
        chk(mode_o === {NCH{2'b10}}, "R6", "mode under uv", int'(mode_o), int'({NCH{2'b10}}));
        uv = 0;
        repeat (2) @(negedge clk);
        chk(pg_o === 1, "R6", "pg after uv", int'(pg_o), 1);

        // enable drop and restart
        en = 0;
        repeat (2) @(negedge clk);
        chk(mode_o === '0, "R1", "enable low", int'(mode_o), 0);
        repeat (10) @(negedge clk);
        en = 1;
        start_edge(t0);
        wait_mode(2'b01, t0, dt); chk(dt == INIT, "R2", "restart ticks to low", dt, INIT);
        wait_mode(2'b10, t0, dt);
        repeat (100) @(negedge clk);

        // over-current in ramp: hiccup
        oc = 1;
        @(negedge clk);
        oc = 0;
        t0 = tick_seen;
        chk(mode_o === '0, "R7", "oc release", int'(mode_o), 0);
        repeat (500) @(negedge clk);
        oc = 1; @(negedge clk); oc = 0;
        wait_mode(2'b01, t0, dt); chk(dt == HIC, "R8", "oc in wait ignored", dt, HIC);
        wait_mode(2'b10, t0, dt); chk(dt == HIC + SET, "R7", "hiccup ticks to pwm", dt, HIC + SET);
        wait_pg(t0, dt);          chk(dt == HIC + SEQ, "R7", "hiccup ticks to pg", dt, HIC + SEQ);

        // second hiccup triggered during settle
        oc = 1; @(negedge clk); oc = 0;
        t0 = tick_seen;
        wait_mode(2'b01, t0, dt);
        repeat (40) @(negedge clk);
        oc = 1; @(negedge clk); oc = 0;
        t0 = tick_seen;
        chk(mode_o === '0, "R8", "repeat oc release", int'(mode_o), 0);
        wait_mode(2'b01, t0, dt); chk(dt == HIC, "R8", "repeat hiccup wait", dt, HIC);
        wait_pg(t0, dt);          chk(dt == HIC + SEQ, "R8", "repeat hiccup pg", dt, HIC + SEQ);

        // over-voltage latch and clamp
        ov = 1; @(negedge clk);
        chk(mode_o === {NCH{2'b01}}, "R5", "clamp low", int'(mode_o), int'({NCH{2'b01}}));
        chk(pg_o === 0, "R5", "pg in clamp", int'(pg_o), 0);
        ov = 0; @(negedge clk);
        chk(mode_o === '0, "R5", "clamp release", int'(mode_o), 0);
        repeat (50) @(negedge clk);
        en = 0; repeat (5) @(negedge clk); en = 1;
        repeat (300) @(negedge clk);
        chk(mode_o === '0 && pg_o === 0, "R5", "no restart while latched", int'(mode_o), 0);
        ov = 1; @(negedge clk);
        chk(mode_o === {NCH{2'b01}}, "R5", "clamp again", int'(mode_o), int'({NCH{2'b01}}));
        ov = 0;
        repeat (3) @(negedge clk);

        // power-on reset clears the latch
        por = 1; repeat (3) @(negedge clk);
        por = 0;
        start_edge(t0);
        wait_mode(2'b01, t0, dt); chk(dt == INIT, "R5", "start after por", dt, INIT);
        wait_pg(t0, dt);          chk(dt == PGC, "R4", "pg after por", dt, PGC);
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule